// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM out of power-up. Once reset is released it drives no-operation commands for a stabilization interval set by the clock frequency and a time in microseconds. After that interval it drives a fixed series of commands: it precharges every bank, runs two auto-refresh cycles, and then loads the mode register. A programmable number of idle cycles follows each command, and NOPs fill every one of those cycles.

The mode register word is built from separate configuration inputs: burst length, burst ordering, read latency and single-location writes. The operating-mode bits are always written as standard. A configuration that selects a reserved latency or a reserved burst length stops the sequence at the point where the mode load would go out. The block then raises an error flag and keeps driving NOPs until the next reset. When the sequence ends normally, a done flag rises and stays high. The memory controller that owns normal traffic and refresh scheduling waits for this flag before it takes over the command pins.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is held, the command pins carry NOP (cs,ras,cas,we = 0,1,1,1), the address and bank buses are zero, clock enable is high, and both flags are low.
- R2: After reset is released, every cycle up to the STABLE_CYC-th rising edge (STABLE_CYC = CLK_MHZ*STABLE_US) carries NOP. The precharge is driven in the cycle after that edge.
- R3: The precharge uses the encoding 0,0,1,0 with address bit 10 high, all other address bits low, and bank address zero, so it targets every bank.
- R4: Exactly two auto-refresh commands (0,0,0,1) are issued. The first comes T_RP cycles after the precharge and the second comes T_RFC cycles after the first.
- R5: The mode load (0,0,0,0, bank address zero) comes T_RFC cycles after the second refresh, and is issued only if the configuration is valid.
- R6: During the mode load the address bus carries the mode word: bits 2:0 burst length, bit 3 burst ordering (1 = interleaved), bits 6:4 read latency, bits 8:7 zero (standard operation), bit 9 single-location writes, bits 12:10 zero.
- R7: Each command lasts exactly one cycle. Every other cycle carries NOP with a zero address bus.
- R8: The done flag rises T_MRD cycles after the mode load and stays high until reset. After that only NOPs are driven, and later changes to the configuration inputs have no effect.
- R9: Clock enable is high in every cycle.
- R10: A read latency code other than 2 or 3, a burst length code 4, 5 or 6, or code 7 with interleaved ordering is invalid. With an invalid configuration the error flag rises in the cycle where the mode load would have been driven, no mode load is ever issued, done stays low, and the error stays high until reset even if the configuration is corrected.
- R11: Burst length code 7 (full page) with sequential ordering is accepted, and its mode load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for mode bits 2:0 |
| cfg_burst_interleave | input | 1 | Burst ordering for mode bit 3 (1 = interleaved) |
| cfg_cas_latency | input | 3 | Read latency code for mode bits 6:4 |
| cfg_write_single | input | 1 | Single-location write mode for mode bit 9 |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (precharge-all bit or mode word) |
| sd_ba | output | BANK_W | Bank address, zero throughout |
| init_done | output | 1 | Sequence complete, sticky until reset |
| cfg_error | output | 1 | Reserved configuration rejected, sticky until reset |

## Verification
A wrong wait count or a wrong state transition shows up as a command that arrives one or more cycles early or late compared with the arithmetic schedule. The bench sees it at the first command that follows the fault, which is at most T_RFC cycles later. A corrupted mode field shows on the address bus in the single mode-load cycle. A bad validity decision shows either as an error flag in place of the mode load or as a mode load in place of the error flag, in that same cycle. The bench runs every combination of the configuration inputs and compares every cycle of every run with its schedule. Each run also changes the configuration after completion or after an error, so that a non-sticky flag or a late command is exposed within a few cycles.

// File: rtl/sdram_init_pkg.sv
// Shared types and encodings for the SDRAM power-up sequencer.
// Assumes the standard active-low command encoding on cs/ras/cas/we.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_STARTUP,
        ST_PRECH,
        ST_REFRESH_A,
        ST_REFRESH_B,
        ST_LOADMODE,
        ST_GAP,
        ST_READY,
        ST_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        KIND_NOP,
        KIND_PRECH,
        KIND_REFRESH,
        KIND_LOADMODE
    } seq_kind_e;

    localparam logic [3:0] PINS_NOP      = 4'b0111;
    localparam logic [3:0] PINS_PRECH    = 4'b0010;
    localparam logic [3:0] PINS_REFRESH  = 4'b0001;
    localparam logic [3:0] PINS_LOADMODE = 4'b0000;

    // Address bit that selects every bank during a precharge.
    localparam int ALL_BANKS_BIT = 10;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
// Down-counter shared by all waits of the sequencer.
// After reset it holds RST_VAL, so the stabilization wait needs no load.
// A load takes priority over counting. The counter stops at zero.
module init_wait_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_VAL);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, or take a new wait length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_CNT;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The wait is over once the counter reaches zero.
    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mode_word_builder.sv
// Builds the mode register word from its fields and reports whether the
// configuration avoids reserved codes. Purely combinational.
// Assumes ADDR_W >= 10.
module mode_word_builder #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        burst_len,
    input  logic              burst_interleave,
    input  logic [2:0]        cas_latency,
    input  logic              write_single,
    output logic [ADDR_W-1:0] mode_word,
    output logic              cfg_ok
);

    logic len_ok;
    logic lat_ok;

    // Place each field at its bit position; the op-mode and upper bits stay zero.
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_len;
        mode_word[3]   = burst_interleave;
        mode_word[6:4] = cas_latency;
        mode_word[8:7] = 2'b00;
        mode_word[9]   = write_single;
    end

    // Accept latency 2 or 3, lengths 1..8, and full page only with sequential ordering.
    always_comb begin
        lat_ok = (cas_latency == 3'd2) || (cas_latency == 3'd3);
        len_ok = (burst_len <= 3'd3) || ((burst_len == 3'd7) && !burst_interleave);
        cfg_ok = lat_ok && len_ok;
    end

endmodule

// File: rtl/init_cmd_encoder.sv
// Maps the command kind chosen by the sequencer onto the command pins,
// address bus and bank bus. The bank bus is always zero.
module init_cmd_encoder
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BANK_W = 2
) (
    input  seq_kind_e         kind,
    input  logic [ADDR_W-1:0] mode_word,
    output logic [3:0]        pins,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba
);

    // Select the pin pattern and the address contents for the current kind.
    always_comb begin
        pins = PINS_NOP;
        addr = '0;
        case (kind)
            KIND_PRECH: begin
                pins                = PINS_PRECH;
                addr[ALL_BANKS_BIT] = 1'b1;
            end
            KIND_REFRESH: begin
                pins = PINS_REFRESH;
            end
            KIND_LOADMODE: begin
                pins = PINS_LOADMODE;
                addr = mode_word;
            end
            default: begin
                pins = PINS_NOP;
            end
        endcase
    end

    assign ba = '0;

endmodule

// File: rtl/init_seq_fsm.sv
// Ordering state machine: stabilization, precharge-all, refresh, refresh,
// mode load, final wait, done. Each command lasts one cycle and is followed
// by a gap state that waits for the shared timer. If the configuration is
// bad when the gap before the mode load ends, the machine halts with an error.
// Assumes every T_* parameter is at least 2.
module init_seq_fsm
    import sdram_init_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int T_RP  = 2,
    parameter int T_RFC = 2,
    parameter int T_MRD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_expired,
    input  logic             cfg_ok,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_value,
    output seq_kind_e        kind,
    output logic             ready,
    output logic             err
);

    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(max2(T_RP, 2) - 2);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(max2(T_RFC, 2) - 2);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(max2(T_MRD, 2) - 2);

    seq_state_e state_q, state_d;
    seq_state_e ret_q, ret_d;

    // Hold the current step and the step to resume after a gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STARTUP;
            ret_q   <= ST_PRECH;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    // Choose the next step and the timer load for the following gap.
    always_comb begin
        state_d     = state_q;
        ret_d       = ret_q;
        timer_load  = 1'b0;
        timer_value = '0;
        case (state_q)
            ST_STARTUP: begin
                if (timer_expired) begin
                    state_d = ST_PRECH;
                end
            end
            ST_PRECH: begin
                timer_load  = 1'b1;
                timer_value = LD_RP;
                ret_d       = ST_REFRESH_A;
                state_d     = ST_GAP;
            end
            ST_REFRESH_A: begin
                timer_load  = 1'b1;
                timer_value = LD_RFC;
                ret_d       = ST_REFRESH_B;
                state_d     = ST_GAP;
            end
            ST_REFRESH_B: begin
                timer_load  = 1'b1;
                timer_value = LD_RFC;
                ret_d       = ST_LOADMODE;
                state_d     = ST_GAP;
            end
            ST_LOADMODE: begin
                timer_load  = 1'b1;
                timer_value = LD_MRD;
                ret_d       = ST_READY;
                state_d     = ST_GAP;
            end
            ST_GAP: begin
                if (timer_expired) begin
                    if ((ret_q == ST_LOADMODE) && !cfg_ok) begin
                        state_d = ST_HALT;
                    end else begin
                        state_d = ret_q;
                    end
                end
            end
            ST_READY: state_d = ST_READY;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // Decode the command kind and the flags from the current step.
    always_comb begin
        case (state_q)
            ST_PRECH:     kind = KIND_PRECH;
            ST_REFRESH_A: kind = KIND_REFRESH;
            ST_REFRESH_B: kind = KIND_REFRESH;
            ST_LOADMODE:  kind = KIND_LOADMODE;
            default:      kind = KIND_NOP;
        endcase
        ready = (state_q == ST_READY);
        err   = (state_q == ST_HALT);
    end

    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    p_error_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_reject_bad_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && ret_q == ST_LOADMODE && timer_expired && !cfg_ok)
        |=> (err && kind == KIND_NOP));

    p_single_cycle_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != KIND_NOP) |=> (kind == KIND_NOP));

endmodule

// File: rtl/sdram_powerup_seq.sv
// Top of the SDRAM power-up sequencer. It ties together the wait timer, the
// ordering state machine, the mode word builder and the pin encoder.
// Assumes CLK_MHZ*STABLE_US >= 1, T_* >= 2 and ADDR_W >= 11.
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 133,
    parameter int STABLE_US = 100,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 9,
    parameter int T_MRD     = 2,
    parameter int ADDR_W    = 13,
    parameter int BANK_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_interleave,
    input  logic [2:0]        cfg_cas_latency,
    input  logic              cfg_write_single,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BANK_W-1:0] sd_ba,
    output logic              init_done,
    output logic              cfg_error
);

    localparam int STABLE_CYC = max2(CLK_MHZ * STABLE_US, 1);
    localparam int MAX_WAIT   = max2(STABLE_CYC, max2(T_RP, max2(T_RFC, T_MRD)));
    localparam int CNT_W      = $clog2(MAX_WAIT + 1);

    logic              timer_load;
    logic [CNT_W-1:0]  timer_value;
    logic              timer_expired;
    logic              cfg_ok;
    logic [ADDR_W-1:0] mode_word;
    seq_kind_e         kind;
    logic [3:0]        pins;

    init_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STABLE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_value),
        .expired  (timer_expired)
    );

    init_seq_fsm #(
        .CNT_W (CNT_W),
        .T_RP  (T_RP),
        .T_RFC (T_RFC),
        .T_MRD (T_MRD)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .timer_expired (timer_expired),
        .cfg_ok        (cfg_ok),
        .timer_load    (timer_load),
        .timer_value   (timer_value),
        .kind          (kind),
        .ready         (init_done),
        .err           (cfg_error)
    );

    mode_word_builder #(
        .ADDR_W (ADDR_W)
    ) u_mode (
        .burst_len        (cfg_burst_len),
        .burst_interleave (cfg_burst_interleave),
        .cas_latency      (cfg_cas_latency),
        .write_single     (cfg_write_single),
        .mode_word        (mode_word),
        .cfg_ok           (cfg_ok)
    );

    init_cmd_encoder #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) u_enc (
        .kind      (kind),
        .mode_word (mode_word),
        .pins      (pins),
        .addr      (sd_addr),
        .ba        (sd_ba)
    );

    // Split the encoded pattern onto the individual command pins.
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
    assign sd_cke = 1'b1;

    p_precharge_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_PRECH) |-> (sd_addr[ALL_BANKS_BIT] && sd_ba == '0));

    p_mode_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_LOADMODE) |-> (sd_addr == mode_word && cfg_ok));

    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == PINS_NOP && sd_addr == '0));

endmodule

// File: tb/test_sdram_powerup_seq.sv
// Sweeps every configuration input combination. For each one it compares
// every cycle of the power-up sequence with an arithmetic schedule.
module test_sdram_powerup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int STABLE_US  = 20;
    localparam int T_RP       = 3;
    localparam int T_RFC      = 5;
    localparam int T_MRD      = 2;
    localparam int ADDR_W     = 13;
    localparam int BANK_W     = 2;

    localparam int S_PRE  = CLK_MHZ * STABLE_US;
    localparam int S_REF1 = S_PRE + T_RP;
    localparam int S_REF2 = S_REF1 + T_RFC;
    localparam int S_LMR  = S_REF2 + T_RFC;
    localparam int S_RDY  = S_LMR + T_MRD;
    localparam int LIMIT  = S_RDY + 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_burst_len = '0;
    logic              cfg_burst_interleave = 1'b0;
    logic [2:0]        cfg_cas_latency = 3'd2;
    logic              cfg_write_single = 1'b0;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BANK_W-1:0] sd_ba;
    logic              init_done, cfg_error;

    int checks = 0;
    int failures = 0;

    sdram_powerup_seq #(
        .CLK_MHZ   (CLK_MHZ),
        .STABLE_US (STABLE_US),
        .T_RP      (T_RP),
        .T_RFC     (T_RFC),
        .T_MRD     (T_MRD),
        .ADDR_W    (ADDR_W),
        .BANK_W    (BANK_W)
    ) i_sdram_powerup_seq (
        .clk                  (clk),
        .rst_n                (rst_n),
        .cfg_burst_len        (cfg_burst_len),
        .cfg_burst_interleave (cfg_burst_interleave),
        .cfg_cas_latency      (cfg_cas_latency),
        .cfg_write_single     (cfg_write_single),
        .sd_cke               (sd_cke),
        .sd_cs_n              (sd_cs_n),
        .sd_ras_n             (sd_ras_n),
        .sd_cas_n             (sd_cas_n),
        .sd_we_n              (sd_we_n),
        .sd_addr              (sd_addr),
        .sd_ba                (sd_ba),
        .init_done            (init_done),
        .cfg_error            (cfg_error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare every port with its expected value in one sample.
    task automatic check_sample(input string tag, input int step,
                                input logic [3:0] e_pins, input int e_addr,
                                input bit e_done, input bit e_err);
        string w;
        w = $sformatf("step %0d pins", step);
        check(tag, w, int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e_pins));
        w = $sformatf("step %0d addr", step);
        check(tag, w, int'(sd_addr), e_addr);
        w = $sformatf("step %0d ba", step);
        check(tag, w, int'(sd_ba), 0);
        w = $sformatf("step %0d cke", step);
        check("R9", w, int'(sd_cke), 1);
        w = $sformatf("step %0d done", step);
        check(e_done ? "R8" : tag, w, int'(init_done), int'(e_done));
        w = $sformatf("step %0d error", step);
        check(e_err ? "R10" : tag, w, int'(cfg_error), int'(e_err));
    endtask

    task automatic run_case(input logic [2:0] bl, input logic bt,
                            input logic [2:0] cl, input logic ws);
        bit         valid;
        int         word;
        logic [3:0] e_pins;
        int         e_addr;
        string      tag;
        valid = ((cl == 3'd2) || (cl == 3'd3)) &&
                ((bl <= 3'd3) || ((bl == 3'd7) && !bt));
        word  = (int'(ws) << 9) | (int'(cl) << 4) | (int'(bt) << 3) | int'(bl);
        cfg_burst_len        = bl;
        cfg_burst_interleave = bt;
        cfg_cas_latency      = cl;
        cfg_write_single     = ws;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_sample("R1", 0, 4'b0111, 0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 1; i <= LIMIT; i++) begin
            @(negedge clk);
            e_pins = 4'b0111;
            e_addr = 0;
            if (i < S_PRE) tag = "R2";
            else if (valid && i >= S_RDY) tag = "R8";
            else if (!valid && i >= S_LMR) tag = "R10";
            else tag = "R7";
            if (i == S_PRE) begin
                e_pins = 4'b0010;
                e_addr = 1 << 10;
                tag = "R3";
            end else if (i == S_REF1 || i == S_REF2) begin
                e_pins = 4'b0001;
                tag = "R4";
            end else if (i == S_LMR && valid) begin
                e_pins = 4'b0000;
                e_addr = word;
                tag = (bl == 3'd7) ? "R11" : "R6";
            end
            if (i == S_LMR && !valid) tag = "R10";
            if (i == S_LMR && valid && tag != "R11") tag = "R5";
            check_sample(tag, i, e_pins, e_addr, valid && (i >= S_RDY),
                         !valid && (i >= S_LMR));
            if (i == S_LMR && valid) begin
                // R6: field layout of the mode word on the address bus
                check("R6", "mode word", int'(sd_addr), word);
            end
            // R8: invalid settings after done; R10: valid settings after error
            if (valid && i == S_RDY + 1) begin
                cfg_burst_len        = 3'd5;
                cfg_burst_interleave = 1'b1;
                cfg_cas_latency      = 3'd7;
                cfg_write_single     = ~ws;
            end
            if (!valid && i == S_LMR + 1) begin
                cfg_burst_len        = 3'd2;
                cfg_burst_interleave = 1'b0;
                cfg_cas_latency      = 3'd3;
                cfg_write_single     = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int bl = 0; bl < 8; bl++) begin
            for (int bt = 0; bt < 2; bt++) begin
                for (int cl = 0; cl < 8; cl++) begin
                    for (int ws = 0; ws < 2; ws++) begin
                        run_case(3'(bl), 1'(bt), 3'(cl), 1'(ws));
                    end
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule